// File: doc/BRIEF.md
# Real-Time Clock Source Select and Battery-Low Monitor

This block is a small control register for a microcontroller's real-time clock and its supply-voltage monitor. A three-bit field picks which of eight prescaler taps drives the real-time clock tick. An enable bit powers the external low-voltage comparator. A read-only bit reports whether the supply is below threshold.

The comparator output needs time to settle after it is switched on. Its level is meaningless while it is off. For these reasons the block qualifies the battery-low bit. The raw comparator level first passes through a two-flop synchronizer. The bit then reads as 1 only once the enable has been held high for a programmable number of clock cycles. The prescaler chain and the analog comparator sit outside the block.

Software writes the low nibble through a single-cycle write strobe. It reads the full byte at any time through a combinational read port.

Top module: `rtc_batt_ctrl`

## Requirements
- R1: `tickOut` always equals `taps[n]`, where n is the select field held in register bits 2:0. The output follows a tap change without a clock delay.
- R2: After reset, the select field is 3'b111 and the enable bit is 0, so `rdData` reads 8'h07.
- R3: A cycle with `wrEn` high loads `wrData[2:0]` into the select field and `wrData[3]` into the enable bit. The new values are visible from the next clock edge. `wrData[7:4]` has no effect on any register bit.
- R4: `detEnable` equals the enable bit (register bit 3) at all times.
- R5: While the enable bit is 0, the battery-low bit (`rdData[5]`) reads 0.
- R6: After each 0-to-1 change of the enable bit, the battery-low bit reads 0 until `SETTLE_CYCLES` clock edges have passed. The count restarts on every such change. Writing 1 while the bit is already 1 does not restart it.
- R7: `rdData[7]`, `rdData[6]` and `rdData[4]` always read 0.
- R8: Once settled, `rdData[5]` equals the `cmpRaw` level sampled two clock edges earlier. A value of 1 means the supply is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrData | input | 8 | Write data; only bits 3:0 are used |
| rdData | output | 8 | Register read value |
| taps | input | 8 | Prescaler tap outputs |
| cmpRaw | input | 1 | Raw, asynchronous comparator result |
| detEnable | output | 1 | Comparator power enable |
| tickOut | output | 1 | Selected real-time clock tick |

## Verification
The assertions take `cmpRaw` as an asynchronous level that is only ever judged through its two-stage delay. They take `wrData` as stable at the sampling edge whenever `wrEn` is high. The prescaler taps are treated as arbitrary values that may change every cycle. The stimulus changes every input on the falling clock edge, so no register samples an input mid-transition. The stimulus also randomizes taps and the comparator level freely. Enable toggles are placed both back-to-back and in the middle of a settling count, so the restart rule of R6 is reached from every neighbouring state.

// File: rtl/rtc_batt_ctrl_pkg.sv
package rtc_batt_ctrl_pkg;
  localparam int SEL_W    = 3;
  localparam int TAP_N    = 1 << SEL_W;
  localparam int REG_W    = 8;
  localparam int EN_BIT   = 3;
  localparam int FLAG_BIT = 5;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             detEn;
    logic             settled;
  } ctrlStrobe_t;
endpackage

// File: rtl/rtc_batt_regs.sv
module rtc_batt_regs
  import rtc_batt_ctrl_pkg::*;
#(
  parameter int SETTLE_CYCLES = 50000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output ctrlStrobe_t      ctrl
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE_CYCLES);

  logic [SEL_W-1:0] selQ;
  logic             enQ;
  logic [CNT_W-1:0] settleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= '1;
      enQ  <= 1'b0;
    end else if (wrEn) begin
      selQ <= wrData[SEL_W-1:0];
      enQ  <= wrData[EN_BIT];
    end
  end

  // Count restarts whenever the enable has been low for a cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 settleCnt <= '0;
    else if (!enQ)             settleCnt <= '0;
    else if (settleCnt != CNT_MAX) settleCnt <= settleCnt + 1'b1;
  end

  always_comb begin
    ctrl.sel     = selQ;
    ctrl.detEn   = enQ;
    ctrl.settled = enQ && (settleCnt == CNT_MAX);
  end

  assert_write_loads_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (ctrl.sel == $past(wrData[SEL_W-1:0])) && (ctrl.detEn == $past(wrData[EN_BIT])));
  assert_hold_no_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(ctrl.sel) && $stable(ctrl.detEn));
  assert_settled_needs_en_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.settled |-> ctrl.detEn);
  assert_restart_on_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrl.detEn) |-> !ctrl.settled);
endmodule

// File: rtl/rtc_batt_datapath.sv
module rtc_batt_datapath
  import rtc_batt_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      ctrl,
  input  logic [TAP_N-1:0] taps,
  input  logic             cmpRaw,
  output logic [REG_W-1:0] rdData,
  output logic             tickOut
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   lowFlag;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[g] <= 1'b0;
        else if (g == 0) syncChain[g] <= cmpRaw;
        else syncChain[g] <= syncChain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign lowFlag = ctrl.settled & syncChain[SYNC_STAGES-1];
  assign tickOut = taps[ctrl.sel];

  always_comb begin
    rdData                   = '0;
    rdData[SEL_W-1:0]        = ctrl.sel;
    rdData[EN_BIT]           = ctrl.detEn;
    rdData[FLAG_BIT]         = lowFlag;
  end

  assert_flag_gated_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.settled |-> !rdData[FLAG_BIT]);
  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdData[7:6] == 2'b00 && rdData[4] == 1'b0);
  assert_flag_tracks_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.settled && $past(ctrl.settled) && $past(ctrl.settled, 2)
      |-> rdData[FLAG_BIT] == $past(cmpRaw, 2));
endmodule

// File: rtl/rtc_batt_ctrl.sv
module rtc_batt_ctrl
  import rtc_batt_ctrl_pkg::*;
#(
  parameter int SETTLE_CYCLES = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic [7:0] taps,
  input  logic       cmpRaw,
  output logic       detEnable,
  output logic       tickOut
);
  ctrlStrobe_t ctrl;

  rtc_batt_regs #(.SETTLE_CYCLES(SETTLE_CYCLES)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .ctrl(ctrl)
  );

  rtc_batt_datapath #(.SYNC_STAGES(2)) uPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .taps(taps), .cmpRaw(cmpRaw),
    .rdData(rdData), .tickOut(tickOut)
  );

  assign detEnable = ctrl.detEn;

  assert_enable_pin_R4: assert property (@(posedge clk) disable iff (!rstN)
    detEnable == rdData[EN_BIT]);
endmodule

// File: tb/tb_rtc_batt_ctrl.sv
module tb_rtc_batt_ctrl;
  localparam int SETTLE = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [7:0] taps = '0;
  logic       cmpRaw = 1'b0;
  logic       detEnable;
  logic       tickOut;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  // Behavioural reference state
  int   mSel = 7;
  bit   mEn = 1'b0;
  int   mOnCycles = 0;
  bit   cmpHist[$];

  rtc_batt_ctrl #(.SETTLE_CYCLES(SETTLE)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .taps(taps), .cmpRaw(cmpRaw), .detEnable(detEnable), .tickOut(tickOut)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycles, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mSel = 7; mEn = 1'b0; mOnCycles = 0;
      cmpHist = '{1'b0, 1'b0};
    end else begin
      if (mEn) mOnCycles++; else mOnCycles = 0;
      if (wrEn) begin
        mSel = int'(wrData[2:0]);
        if (!mEn && wrData[3]) mOnCycles = 0;
        mEn = wrData[3];
      end
      if (!mEn) mOnCycles = 0;
      cmpHist.push_back(cmpRaw);
      void'(cmpHist.pop_front());
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      logic [7:0] expRd;
      bit flagExp;
      flagExp = mEn && (mOnCycles >= SETTLE) && cmpHist[0];
      expRd = {2'b00, flagExp, 1'b0, mEn, 3'(mSel)};
      check("R3 register bits 3:0", {4'h0, rdData[3:0]}, {4'h0, expRd[3:0]});
      check("R5/R6/R8 battery-low bit", {7'h0, rdData[5]}, {7'h0, expRd[5]});
      check("R7 reserved bits", {rdData[7:6], 1'b0, rdData[4], 4'h0}, 8'h00);
      check("R4 detEnable", {7'h0, detEnable}, {7'h0, mEn});
      check("R1 tickOut", {7'h0, tickOut}, {7'h0, taps[mSel]});
    end
  end

  task automatic doWrite(input logic [7:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0; wrData = $urandom;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      taps = $urandom;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R2 reset read value", rdData, 8'h07);
    check("R2 reset detEnable", {7'h0, detEnable}, 8'h00);

    // R1: every select value with changing taps
    for (int s = 0; s < 8; s++) begin
      doWrite(8'(s));
      for (int k = 0; k < 4; k++) begin
        @(negedge clk); taps = $urandom; #1;
        check("R1 direct tick follow", {7'h0, tickOut}, {7'h0, taps[s]});
      end
    end

    // R3: upper write bits ignored
    doWrite(8'hF5);
    idle(2);
    doWrite(8'hA2);
    idle(2);

    // R6/R8: enable with comparator high, through settling
    cmpRaw = 1'b1;
    doWrite(8'h0E);
    idle(SETTLE + 5);
    cmpRaw = 1'b0; idle(4);
    cmpRaw = 1'b1; idle(4);

    // R6: write 1 while already 1, no restart
    doWrite(8'h09);
    idle(4);

    // R5: disable, flag gone
    doWrite(8'h01);
    idle(4);

    // R6: back-to-back off/on, then restart mid count
    doWrite(8'h0B);
    idle(SETTLE / 2);
    doWrite(8'h03);
    doWrite(8'h0B);
    idle(SETTLE + 3);

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      taps = $urandom;
      cmpRaw = $urandom_range(0, 3) == 0 ? ~cmpRaw : cmpRaw;
      if ($urandom_range(0, 40) == 0) begin
        wrEn = 1'b1;
        wrData = $urandom;
      end else begin
        wrEn = 1'b0;
      end
    end
    @(negedge clk); wrEn = 1'b0;
    idle(3);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule